// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose pin controller for up to 32 pins. It sits behind a simple 32-bit register bus that writes in one cycle and reads combinationally. Each pin has a direction bit and an output latch. Its synchronized input level can be read back. Each pin can also act as an interrupt source.

The interrupt trigger of a pin is set by three per-pin bits: an edge-mode bit, a polarity bit and a dual-edge bit. With these bits a pin fires on a high level, a low level, a rising edge, a falling edge or any transition. Detected events are latched into a raw status register. They are masked by a per-pin enable register to form the pending set, and the pending set is ORed onto one interrupt line to the host. Software acknowledges an event by writing ones to a clear register. A read-only version register lets software find out whether the dual-edge option is built in. That option is present when the version is 3 or higher.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset the following hold. The direction register reads all ones over the implemented pins, so every pin is an input. The output latch, enable register, dual-edge register and raw status read 0. The edge-mode and polarity registers read all ones, so every pin is in rising-edge mode. The irq output is 0.
- R2: A direction bit of 0 makes the pin an output: pin_oe is 1 and pin_out carries the output-latch bit. Reading the data register returns the output-latch bit for an output pin and the synchronized pin level for an input pin.
- R3: With the edge-mode bit at 0 the pin is level triggered. Polarity 1 fires while the synchronized level is high, and polarity 0 fires while it is low.
- R4: With the edge-mode bit at 1 and the dual-edge bit at 0, polarity 1 fires on a 0-to-1 change of the synchronized level and polarity 0 fires on a 1-to-0 change. The opposite change does not fire.
- R5: With the edge-mode bit and the dual-edge bit both at 1, either change of the synchronized level fires. When VERSION is below 3 the dual-edge register reads 0 and ignores writes.
- R6: Writing a 1 to a bit of the clear register clears that pin's raw status bit, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R7: The raw status register latches every detected event regardless of enable. The pending register reads the raw status ANDed with the enable register.
- R8: irq is 1 exactly when at least one pending bit is 1.
- R9: In level mode a cleared status bit is set again on the next clock edge while the active level persists.
- R10: A pin change driven before clock edge n appears in the data register after edge n+1. For an edge that fires, the status bit and irq are set after edge n+2.
- R11: The version register reads the VERSION parameter and ignores writes. Register bits at or above PINS read 0 and ignore writes.
- R12: Byte offsets on bus_addr: data 0x00, direction 0x04, enable 0x08, raw status 0x0C, pending 0x10, clear 0x14, edge-mode 0x18, polarity 0x1C, version 0x20, dual-edge 0x24. The clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Output-latch values |
| pin_oe | output | PINS | Output enable, 1 for pins set as outputs |
| irq | output | 1 | Combined interrupt to the host |

## Verification
A register write takes effect at the clock edge that samples it, so the bench checks the written state at the following falling edge. The bench drives a pin change at a falling edge. It expects the data register to show the change two rising edges later and the status bit and irq one edge after that, and it checks the cycle before each of these as well. In the trigger-table walk the bench waits four edges after each pin change before reading status, which leaves a margin past the three-edge latency. The level-mode re-assertion check reads status at the first falling edge after the clear write, where an edge-mode bit would already read 0.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the pin controller: register word indices and the
// per-pin trigger configuration. Assumes word-aligned byte addresses.
package gpio_irq_pkg;

    localparam int ADDR_W = 6;

    // Word index of each register (byte address bits [5:2])
    typedef enum logic [3:0] {
        IDX_DATA = 4'd0,
        IDX_DIR  = 4'd1,
        IDX_IEN  = 4'd2,
        IDX_STAT = 4'd3,
        IDX_PEND = 4'd4,
        IDX_CLR  = 4'd5,
        IDX_EDGE = 4'd6,
        IDX_POL  = 4'd7,
        IDX_VER  = 4'd8,
        IDX_BOTH = 4'd9
    } reg_idx_e;

    // Trigger selection of one pin
    typedef struct packed {
        logic edge_mode;
        logic pol;
        logic both;
    } trig_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous pin levels.
// Assumes each bit is treated on its own (no multi-bit coherence).
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/gpio_event_det.sv
// Trigger detector for one pin: level, single edge or dual edge, compared
// against the previous synchronized sample. Assumes a synchronized input.
// BOTH_OK selects whether the dual-edge mode is built in.
module gpio_event_det
    import gpio_irq_pkg::*;
#(
    parameter bit BOTH_OK = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_i,
    input  trig_cfg_t cfg_i,
    output logic      evt_o
);

    logic prev_q;
    logic rise;
    logic fall;
    logic edge_hit;

    // Hold the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise = smp_i & ~prev_q;
    assign fall = ~smp_i & prev_q;

    generate
        if (BOTH_OK) begin : g_both
            // Edge selection with the dual-edge option
            always_comb begin
                if (cfg_i.both) edge_hit = rise | fall;
                else            edge_hit = cfg_i.pol ? rise : fall;
            end
        end else begin : g_single
            // Edge selection without the dual-edge option
            always_comb edge_hit = cfg_i.pol ? rise : fall;
        end
    endgenerate

    // Level or edge event for this cycle
    always_comb begin
        if (cfg_i.edge_mode) evt_o = edge_hit;
        else                 evt_o = cfg_i.pol ? smp_i : ~smp_i;
    end

endmodule

// File: rtl/gpio_status_bank.sv
// Raw interrupt status latches: set by events and cleared by write-one.
// An event in the same cycle as a clear wins. Assumes clr_i is a
// single-cycle strobe.
module gpio_status_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] status_o
);

    logic [W-1:0] status_q;
    logic [W-1:0] status_d;

    // Next status: clear the selected bits, then OR in new events
    always_comb begin
        status_d = status_q;
        if (clr_i) status_d = status_d & ~clr_mask_i;
        status_d = status_d | evt_i;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Memory-mapped pin controller with per-pin interrupt triggers.
// Assumes single-cycle writes, combinational reads, word-aligned addresses
// and 1 <= PINS <= 32. The dual-edge register exists when VERSION >= 3.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int PINS    = 16,
    parameter int VERSION = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);

    localparam bit HAS_BOTH = (VERSION >= 3);

    reg_idx_e        idx;
    logic [PINS-1:0] wpins;
    logic [PINS-1:0] out_q, dir_q, ien_q, edge_q, pol_q, both_q;
    logic [PINS-1:0] smp, evt, status_q, pend;
    logic [PINS-1:0] data_view;
    logic            clr_we;

    assign idx    = reg_idx_e'(bus_addr[5:2]);
    assign wpins  = bus_wdata[PINS-1:0];
    assign clr_we = bus_we && (idx == IDX_CLR);

    // Configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '1;
            ien_q  <= '0;
            edge_q <= '1;
            pol_q  <= '1;
        end else if (bus_we) begin
            case (idx)
                IDX_DATA: out_q  <= wpins;
                IDX_DIR:  dir_q  <= wpins;
                IDX_IEN:  ien_q  <= wpins;
                IDX_EDGE: edge_q <= wpins;
                IDX_POL:  pol_q  <= wpins;
                default:  ;
            endcase
        end
    end

    generate
        if (HAS_BOTH) begin : g_both_reg
            // Dual-edge register, present only in versions with the option
            always_ff @(posedge clk) begin
                if (!rst_n)                          both_q <= '0;
                else if (bus_we && idx == IDX_BOTH)  both_q <= wpins;
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    gpio_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (smp)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            trig_cfg_t cfg;
            assign cfg = '{edge_mode: edge_q[i], pol: pol_q[i], both: both_q[i]};
            gpio_event_det #(.BOTH_OK(HAS_BOTH)) u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .smp_i (smp[i]),
                .cfg_i (cfg),
                .evt_o (evt[i])
            );
        end
    endgenerate

    gpio_status_bank #(.W(PINS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .clr_i      (clr_we),
        .clr_mask_i (wpins),
        .status_o   (status_q)
    );

    assign pend      = status_q & ien_q;
    assign irq       = |pend;
    assign pin_out   = out_q;
    assign pin_oe    = ~dir_q;
    assign data_view = (dir_q & smp) | (~dir_q & out_q);

    // Combinational read multiplexer
    always_comb begin
        case (idx)
            IDX_DATA: bus_rdata = 32'(data_view);
            IDX_DIR:  bus_rdata = 32'(dir_q);
            IDX_IEN:  bus_rdata = 32'(ien_q);
            IDX_STAT: bus_rdata = 32'(status_q);
            IDX_PEND: bus_rdata = 32'(pend);
            IDX_EDGE: bus_rdata = 32'(edge_q);
            IDX_POL:  bus_rdata = 32'(pol_q);
            IDX_VER:  bus_rdata = 32'(VERSION);
            IDX_BOTH: bus_rdata = 32'(both_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Property checker for gpio_irq_ctrl, attached by bind. Observes ports and
// the status and enable registers. Assumes reset is held two or more cycles.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int PINS    = 16,
    parameter int VERSION = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   status_q,
    input logic [PINS-1:0]   ien_q,
    input logic              irq
);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0)); // R8

    AST_STATUS_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q) & ~status_q)) |-> $past(bus_we && bus_addr[5:2] == 4'(IDX_CLR))); // R6

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(pin_out)); // R2

    AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'(IDX_PEND)) |-> ((bus_rdata[PINS-1:0] & ~ien_q) == '0)); // R7

    AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'(IDX_VER)) |-> (bus_rdata == 32'(VERSION))); // R11

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .status_q  (status_q),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    localparam int PINS = 16;
    localparam logic [31:0] MASK = 32'h0000_FFFF;
    localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08,
        A_STAT = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_EDGE = 6'h18,
        A_POL = 6'h1C, A_VER = 6'h20, A_BOTH = 6'h24;

    // {edge_mode, pol, both, from_level, to_level, expected_status}
    localparam logic [5:0] VEC [9] = '{
        6'b0_1_0_0_1_1,  // R3 level high fires
        6'b0_1_0_0_0_0,  // R3 level high, stays low
        6'b0_0_0_1_0_1,  // R3 level low fires
        6'b1_1_0_0_1_1,  // R4 rising
        6'b1_1_0_1_0_0,  // R4 rising ignores fall
        6'b1_0_0_1_0_1,  // R4 falling
        6'b1_0_0_0_1_0,  // R4 falling ignores rise
        6'b1_0_1_0_1_1,  // R5 dual, rise
        6'b1_1_1_1_0_1   // R5 dual, fall
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic            irq;
    int              n_run = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.PINS(PINS), .VERSION(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        rd(A_DIR, d);  chk("R1 dir", d, MASK);
        rd(A_IEN, d);  chk("R1 enable", d, 32'h0);
        rd(A_EDGE, d); chk("R1 edge-mode", d, MASK);
        rd(A_POL, d);  chk("R1 polarity", d, MASK);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        rd(A_BOTH, d); chk("R1 dual-edge", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);

        // R10 latency on pin 2 (rising edge by reset)
        @(negedge clk); pin_in[2] = 1'b1;
        wait_n(1); rd(A_DATA, d); chk("R10 data after 1 edge", 32'(d[2]), 32'h0);
        wait_n(1); rd(A_DATA, d); chk("R10 data after 2 edges", 32'(d[2]), 32'h1);
        rd(A_STAT, d); chk("R10 status after 2 edges", 32'(d[2]), 32'h0);
        wait_n(1); rd(A_STAT, d); chk("R10 status after 3 edges", 32'(d[2]), 32'h1);

        // R7 / R8 masking of pending
        rd(A_PEND, d); chk("R7 pending masked", d, 32'h0);
        chk("R8 irq off while masked", 32'(irq), 32'h0);
        wr(A_IEN, 32'h4);
        rd(A_PEND, d); chk("R7 pending enabled", d, 32'h4);
        chk("R8 irq on", 32'(irq), 32'h1);

        // R6 clear with zero then with one
        wr(A_CLR, 32'h0);
        rd(A_STAT, d); chk("R6 zero write keeps", d, 32'h4);
        wr(A_CLR, 32'h4);
        rd(A_STAT, d); chk("R6 one write clears", d, 32'h0);
        chk("R8 irq off after clear", 32'(irq), 32'h0);
        rd(A_CLR, d); chk("R12 clear reads zero", d, 32'h0);
        wr(A_IEN, 32'h0);

        // R2 output pin
        wr(A_DIR, MASK & ~32'h2);
        wr(A_DATA, 32'h2);
        chk("R2 pin_out", 32'(pin_out[1]), 32'h1);
        chk("R2 pin_oe", 32'(pin_oe), 32'h2);
        rd(A_DATA, d); chk("R2 readback", d & 32'h6, 32'h6);

        // R11 version read-only and unused bits
        wr(A_VER, 32'h0);
        rd(A_VER, d); chk("R11 version", d, 32'd3);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, d); chk("R11 upper bits", d, MASK);
        wr(A_IEN, 32'h0);

        // R3 R4 R5 trigger table on pin 0
        for (int v = 0; v < 9; v++) begin
            wr(A_EDGE, MASK & {31'h0, VEC[v][5]} | (MASK & ~32'h1));
            wr(A_POL, {31'h0, VEC[v][4]} | (MASK & ~32'h1));
            wr(A_BOTH, {31'h0, VEC[v][3]});
            @(negedge clk); pin_in[0] = VEC[v][2];
            wait_n(5);
            wr(A_CLR, 32'h1);
            wait_n(1);
            @(negedge clk); pin_in[0] = VEC[v][1];
            wait_n(4);
            rd(A_STAT, d);
            chk($sformatf("R3/R4/R5 vector %0d", v), 32'(d[0]), 32'(VEC[v][0]));
        end

        // R9 level re-assertion after clear
        wr(A_EDGE, MASK & ~32'h1);
        wr(A_POL, MASK);
        wr(A_BOTH, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1;
        wait_n(4);
        wr(A_CLR, 32'h1);
        rd(A_STAT, d); chk("R9 level re-sets", 32'(d[0]), 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule